// File: doc/BRIEF.md
# Age-Tracked Running Insertion Sorter

The block holds a fixed-length window of values in ascending order, from slot 0 (smallest) to slot DEPTH-1 (largest). Each slot also carries an age tag. On each insert strobe, the entry whose age tag is all ones (the oldest) leaves the window. The incoming value then takes its ordered place. A single cycle of parallel compare logic does the whole update; there is no serial search. It suits order-statistic estimators over a sliding window, where the window moves by one sample per strobe and every rank has to be available at once.

Three status words drive each update. A comparison word marks the slots whose value is strictly greater than the new one. A one-hot word marks the slot of the oldest entry. The insertion word is built from these two, bit by bit, around the transition in the comparison word. Which side of the transition it picks depends on whether the departing value lies below or above the new one. Only the entries between the insertion slot and the departing slot move, each by one position. The new entry normally receives age 0. An optional input may assign a different age, which suits windows whose samples do not arrive in time order. A multiplexer returns the entry at a chosen rank.

Top module: `age_rank_sorter`

## Requirements
- R1: After reset every stored value is 0 and slot i holds age i, so slot DEPTH-1 holds the oldest entry.
- R2: On each strobe exactly one entry leaves the window: the one whose age equals DEPTH-1 (all ones). The window length never changes.
- R3: Stored values stay non-decreasing from slot 0 to slot DEPTH-1 after every update.
- R4: The new value is placed after every remaining entry that is less than or equal to it and before the first one that is strictly greater, so a value equal to stored ones goes after them.
- R5: A new value smaller than all remaining entries lands in slot 0. One greater than or equal to all of them lands in slot DEPTH-1.
- R6: Only the entries between the insertion slot and the departing slot change position, each by exactly one slot. Every other entry keeps its slot.
- R7: The new entry receives age 0 when ins_age_en is low and ins_age when it is high. Every remaining entry whose age is greater than or equal to the new entry's age gains one; the others keep their age.
- R8: rank_data_o shows the value in slot rank_sel (rank 0 = smallest) in the same cycle, combinationally.
- R9: With ins_valid low, values and ages hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert strobe, one update per cycle it is high |
| ins_data | input | DW | Value to insert |
| ins_age_en | input | 1 | Use ins_age instead of 0 as the new entry's age |
| ins_age | input | log2(DEPTH) | Age to assign when ins_age_en is high |
| rank_sel | input | log2(DEPTH) | Rank to select, 0 = smallest |
| sorted_o | output | DEPTH*DW | Sorted values, slot i at bits [i*DW +: DW] |
| ages_o | output | DEPTH*log2(DEPTH) | Age tags, slot i at bits [i*log2(DEPTH) +: log2(DEPTH)] |
| rank_data_o | output | DW | Value at the selected rank |

## Verification
The bench aims at the two placement cases: the departing entry lies below the new value, or it lies above it. A design that chose the wrong side of the comparison transition would leave a hole, or duplicate a neighbour, next to the insertion point. Ties are driven repeatedly and checked through the age array. A design that put an equal value in front of existing equals would show the age-0 tag in the wrong slot even though the values match. New minima and maxima exercise the first and last insertion bits. Assigned ages check that only ages at or above the assigned one are incremented; incrementing them all would create a second oldest entry and corrupt later removals.

// File: rtl/sorter_pkg.sv
package sorter_pkg;
   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/rs_status_words.sv
module rs_status_words #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   parameter int AW    = 3
) (
   input  logic [DEPTH-1:0][DW-1:0] vals,
   input  logic [DEPTH-1:0][AW-1:0] ages,
   input  logic [DW-1:0]            new_val,
   output logic [DEPTH-1:0]         gt_w,
   output logic [DEPTH-1:0]         old_w,
   output logic [DEPTH-1:0]         at_or_above_old,
   output logic                     old_below
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign gt_w[i]  = new_val < vals[i];
      assign old_w[i] = &ages[i];
      if (i == 0) begin : g_first
         assign at_or_above_old[i] = old_w[i];
      end else begin : g_rest
         assign at_or_above_old[i] = at_or_above_old[i-1] | old_w[i];
      end
   end
   assign old_below = |(old_w & ~gt_w);
endmodule

// File: rtl/rs_place_words.sv
module rs_place_words #(
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0] gt_w,
   input  logic [DEPTH-1:0] old_w,
   input  logic [DEPTH-1:0] at_or_above_old,
   input  logic             old_below,
   output logic [DEPTH-1:0] ins_w,
   output logic [DEPTH-1:0] take_up,
   output logic [DEPTH-1:0] take_down
);
   logic [DEPTH-1:0] first_gt;
   logic [DEPTH-1:0] last_le;

   for (genvar i = 0; i < DEPTH; i++) begin : g_bit
      if (i == 0) begin : g_lo_edge
         assign first_gt[i] = gt_w[i];
      end else begin : g_lo_mid
         assign first_gt[i] = gt_w[i] & ~gt_w[i-1];
      end
      if (i == DEPTH - 1) begin : g_hi_edge
         assign last_le[i] = ~gt_w[i];
         assign take_up[i] = 1'b0;
      end else begin : g_hi_mid
         assign last_le[i] = ~gt_w[i] & gt_w[i+1];
         assign take_up[i] = old_below & at_or_above_old[i] & ~gt_w[i] & ~ins_w[i];
      end
      assign ins_w[i] = old_below ? last_le[i] : first_gt[i];
      if (i == 0) begin : g_no_down
         assign take_down[i] = 1'b0;
      end else begin : g_down
         assign take_down[i] = ~old_below & gt_w[i] & ~ins_w[i] &
                               (~at_or_above_old[i] | old_w[i]);
      end
   end
endmodule

// File: rtl/rs_rank_mux.sv
module rs_rank_mux #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   parameter int AW    = 3
) (
   input  logic [DEPTH-1:0][DW-1:0] vals,
   input  logic [AW-1:0]            sel,
   output logic [DW-1:0]            dout
);
   assign dout = vals[sel];
endmodule

// File: rtl/age_rank_sorter.sv
module age_rank_sorter #(
   parameter int  DEPTH = 8,
   parameter int  DW    = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ins_valid,
   input  logic [DW-1:0]         ins_data,
   input  logic                  ins_age_en,
   input  logic [AW-1:0]         ins_age,
   input  logic [AW-1:0]         rank_sel,
   output logic [DEPTH*DW-1:0]   sorted_o,
   output logic [DEPTH*AW-1:0]   ages_o,
   output logic [DW-1:0]         rank_data_o
);
   import sorter_pkg::*;

   if (!is_pow2(DEPTH)) begin : g_bad_depth
      initial $error("age_rank_sorter: DEPTH must be a power of two >= 2");
   end
   if (DW < 1) begin : g_bad_width
      initial $error("age_rank_sorter: DW must be at least 1");
   end

   logic [DEPTH-1:0][DW-1:0] val_q, val_d, val_up, val_dn;
   logic [DEPTH-1:0][AW-1:0] age_q, age_d, age_up, age_dn;
   logic [DEPTH-1:0]         gt_w, old_w, ge_old, ins_w, take_up, take_down;
   logic                     old_below;
   logic [AW-1:0]            new_age;

   assign new_age = ins_age_en ? ins_age : '0;

   rs_status_words #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_status (
      .vals(val_q), .ages(age_q), .new_val(ins_data),
      .gt_w(gt_w), .old_w(old_w), .at_or_above_old(ge_old), .old_below(old_below)
   );

   rs_place_words #(.DEPTH(DEPTH)) u_place (
      .gt_w(gt_w), .old_w(old_w), .at_or_above_old(ge_old), .old_below(old_below),
      .ins_w(ins_w), .take_up(take_up), .take_down(take_down)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_nbr
      if (i == DEPTH - 1) begin : g_top
         assign val_up[i] = val_q[i];
         assign age_up[i] = age_q[i];
      end else begin : g_up
         assign val_up[i] = val_q[i+1];
         assign age_up[i] = age_q[i+1];
      end
      if (i == 0) begin : g_bot
         assign val_dn[i] = val_q[i];
         assign age_dn[i] = age_q[i];
      end else begin : g_dn
         assign val_dn[i] = val_q[i-1];
         assign age_dn[i] = age_q[i-1];
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         logic [DW-1:0] sv;
         logic [AW-1:0] sa;
         sv = val_q[i];
         sa = age_q[i];
         if (take_up[i]) begin
            sv = val_up[i];
            sa = age_up[i];
         end else if (take_down[i]) begin
            sv = val_dn[i];
            sa = age_dn[i];
         end
         if (sa >= new_age) sa = sa + AW'(1);
         if (ins_w[i]) begin
            sv = ins_data;
            sa = new_age;
         end
         val_d[i] = sv;
         age_d[i] = sa;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            val_q[i] <= '0;
            age_q[i] <= AW'(i);
         end
      end else if (ins_valid) begin
         val_q <= val_d;
         age_q <= age_d;
      end
   end

   rs_rank_mux #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_rank (
      .vals(val_q), .sel(rank_sel), .dout(rank_data_o)
   );

   assign sorted_o = val_q;
   assign ages_o   = age_q;

   function automatic logic in_order(input logic [DEPTH-1:0][DW-1:0] v);
      for (int i = 0; i < DEPTH - 1; i++)
         if (v[i] > v[i+1]) return 1'b0;
      return 1'b1;
   endfunction

   // R2: exactly one slot holds the oldest age
   a_r2_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(old_w) == 1);

   // R3: stored values remain in ascending order
   a_r3_ordered: assert property (@(posedge clk) disable iff (!rst_n)
      in_order(val_q));

   // R4: comparison word is a thermometer (one 0-to-1 step from low to high slots)
   a_r4_cmp_thermo: assert property (@(posedge clk) disable iff (!rst_n)
      ((gt_w << 1) & ~gt_w) == '0);

   // R4: exactly one insertion slot on a strobe
   a_r4_ins_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |-> $countones(ins_w) == 1);

   // R9: no strobe, no change
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> ($stable(val_q) && $stable(age_q)));
endmodule

// File: tb/age_rank_sorter_tb_top.sv
module age_rank_sorter_tb_top;
   localparam int N  = 8;
   localparam int DW = 8;
   localparam int AW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ins_valid = 1'b0;
   logic [DW-1:0] ins_data = '0;
   logic ins_age_en = 1'b0;
   logic [AW-1:0] ins_age = '0;
   logic [AW-1:0] rank_sel = '0;
   logic [N*DW-1:0] sorted_o;
   logic [N*AW-1:0] ages_o;
   logic [DW-1:0] rank_data_o;

   always #10 clk = ~clk;

   age_rank_sorter #(.DEPTH(N), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_data(ins_data),
      .ins_age_en(ins_age_en), .ins_age(ins_age), .rank_sel(rank_sel),
      .sorted_o(sorted_o), .ages_o(ages_o), .rank_data_o(rank_data_o)
   );

   typedef struct {
      logic [N*DW-1:0] v;
      logic [N*AW-1:0] a;
      logic [DW-1:0]   r;
      string           tag;
   } exp_t;

   exp_t q[$];
   int errors = 0;
   int checks = 0;
   int mv[N];
   int ma[N];
   bit done = 0;

   task automatic check(input string tag, input logic [N*DW-1:0] act,
                        input logic [N*DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [N*DW-1:0] pack_v();
      logic [N*DW-1:0] p;
      for (int i = 0; i < N; i++) p[i*DW +: DW] = DW'(mv[i]);
      return p;
   endfunction

   function automatic logic [N*AW-1:0] pack_a();
      logic [N*AW-1:0] p;
      for (int i = 0; i < N; i++) p[i*AW +: AW] = AW'(ma[i]);
      return p;
   endfunction

   // Reference model: drop the oldest, re-age, insert after all <= entries.
   task automatic model_ins(input int v, input bit aen, input int a);
      int tv[$];
      int ta[$];
      int na;
      int p;
      na = aen ? a : 0;
      for (int i = 0; i < N; i++) begin
         if (ma[i] != N - 1) begin
            tv.push_back(mv[i]);
            ta.push_back(ma[i] >= na ? ma[i] + 1 : ma[i]);
         end
      end
      p = 0;
      for (int i = 0; i < tv.size(); i++) if (tv[i] <= v) p = i + 1;
      tv.insert(p, v);
      ta.insert(p, na);
      for (int i = 0; i < N; i++) begin
         mv[i] = tv[i];
         ma[i] = ta[i];
      end
   endtask

   task automatic do_ins(input int v, input bit aen, input int a, input int rs,
                         input string tag);
      exp_t e;
      @(negedge clk);
      ins_valid  = 1'b1;
      ins_data   = DW'(v);
      ins_age_en = aen;
      ins_age    = AW'(a);
      rank_sel   = AW'(rs);
      model_ins(v, aen, a);
      e.v = pack_v();
      e.a = pack_a();
      e.r = DW'(mv[rs]);
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   // Monitor: compare the state one register after each strobe.
   always @(posedge clk) begin
      logic seen;
      exp_t e;
      seen = ins_valid && rst_n;
      #5;
      if (seen) begin
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual=update expected=none");
         end else begin
            e = q.pop_front();
            check({e.tag, " values"}, sorted_o, e.v);
            check({e.tag, " R7 ages"}, {{(N*DW-N*AW){1'b0}}, ages_o},
                  {{(N*DW-N*AW){1'b0}}, e.a});
            check({e.tag, " R8 rank"}, {{(N*DW-DW){1'b0}}, rank_data_o},
                  {{(N*DW-DW){1'b0}}, e.r});
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [N*DW-1:0] snap_v;
      logic [N*AW-1:0] snap_a;
      for (int i = 0; i < N; i++) begin
         mv[i] = 0;
         ma[i] = i;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 reset values", sorted_o, pack_v());
      check("R1 reset ages", {{(N*DW-N*AW){1'b0}}, ages_o},
            {{(N*DW-N*AW){1'b0}}, pack_a()});

      // R2 R4: ascending fill, each new value is the largest (R5 upper edge)
      for (int i = 1; i <= N; i++) do_ins(i * 10, 0, 0, N - 1, "R2 R5 ascending");
      // R5: new minimum goes to slot 0, departing entry above
      for (int i = 0; i < 4; i++) do_ins(3 - i, 0, 0, 0, "R5 R6 new minimum");
      // R4: equal values go after existing equals
      for (int i = 0; i < 6; i++) do_ins(50, 0, 0, 3, "R4 ties");
      // R6: middle values, departing entry on either side
      do_ins(45, 0, 0, 4, "R6 middle");
      do_ins(200, 0, 0, 7, "R6 above");
      do_ins(1, 0, 0, 1, "R6 below");
      // R7: assigned ages
      do_ins(60, 1, 4, 2, "R7 assigned age");
      do_ins(5, 1, N - 1, 5, "R7 assigned oldest");
      do_ins(70, 1, 1, 6, "R7 assigned low");

      // R9: idle cycles hold state
      @(negedge clk);
      snap_v = sorted_o;
      snap_a = ages_o;
      repeat (4) @(negedge clk);
      check("R9 hold values", sorted_o, snap_v);
      check("R9 hold ages", {{(N*DW-N*AW){1'b0}}, ages_o},
            {{(N*DW-N*AW){1'b0}}, snap_a});

      // R8: rank sweep without updates
      for (int r = 0; r < N; r++) begin
         rank_sel = AW'(r);
         #1;
         check("R8 rank sweep", {{(N*DW-DW){1'b0}}, rank_data_o},
               {{(N*DW-DW){1'b0}}, DW'(mv[r])});
         @(negedge clk);
      end

      // R3: random stream with small value range for duplicates
      for (int k = 0; k < 300; k++) begin
         int v;
         bit aen;
         v = int'($urandom_range(0, 15));
         aen = ($urandom_range(0, 3) == 0);
         do_ins(v, aen, int'($urandom_range(0, N - 1)), int'($urandom_range(0, N - 1)),
                "R3 random");
      end
      repeat (3) @(negedge clk);
      begin
         bit ok;
         ok = 1;
         for (int i = 0; i < N - 1; i++)
            if (sorted_o[i*DW +: DW] > sorted_o[(i+1)*DW +: DW]) ok = 0;
         checks++;
         if (!ok) begin
            errors++;
            $display("FAIL R3 order: actual=%h expected=ascending", sorted_o);
         end
      end
      finish_run();
   end
endmodule